// File: doc/BRIEF.md
# Privileged Status Word Update Unit

This unit owns a 16-bit processor status word and applies every change that software can make to it. The low byte holds the condition flags and the high byte holds the system bits, including the supervisor flag. A caller raises `start` with an operation code, a byte/word select, a 16-bit source value, the address that follows the opcode word, and the current active and alternate stack pointers. Two clock edges later the unit pulses `done` for one cycle. With that pulse it presents the new status word, the stack pointers (exchanged if the supervisor flag changed), the status value for read operations, a cycle cost, and, when a word-wide write was tried from user mode, an exception request with vector offset 0x20 and a return address that points back at the opcode word.

The controller is a three-state machine. `S_IDLE` waits for `start` and latches the operands (transition IDLE->EVAL on `start`). `S_EVAL` computes the result, decides the privilege outcome, and commits the status word, pointers and report registers (transition EVAL->RESP, unconditional). `S_RESP` drives `done` (transition RESP->IDLE, unconditional). `start` is only sampled in `S_IDLE`.

Top module: `psw_update`

## Requirements
- R1: A synchronous active-high `rst` sets `sr` to 0x2700 and drives `done` and `exc_req` to 0. It also clears `sp_act_out`, `sp_alt_out`, `rd_data` and `cycles` to 0.
- R2: `start` sampled high in idle produces exactly one `done` cycle. That cycle is the second rising edge after the sampling edge. `start` raised while an operation is in flight is ignored.
- R3: The condition byte uses bit 0 for carry, bit 1 for overflow, bit 2 for zero, bit 3 for negative and bit 4 for extend. `sr[7:5]` always reads 0. In the high byte, only the bits of mask 0xA7 can ever be 1.
- R4: With `op`=2 (move), `is_word`=1 loads the whole word from `src` (masked as in R3). `is_word`=0 replaces only the low byte and leaves `sr[15:8]` unchanged.
- R5: With `op`=3/4/5, the unit applies OR/AND/XOR between `src` and the current `sr`, then masks as in R3. With `is_word`=0, only the low byte changes.
- R6: A word-wide write (`op` 2 to 5 with `is_word`=1) while `sr[13]`=0 leaves `sr` and the pointers unchanged. It raises `exc_req` with `exc_vec`=0x20, `exc_pc`=`op_pc`-2 (modulo 2^PC_W) and `cycles`=34.
- R7: Byte-wide writes and reads never raise `exc_req`, whatever the value of `sr[13]`.
- R8: When a write changes `sr[13]`, `sp_act_out` equals the `sp_alt_in` latched at start and `sp_alt_out` equals the latched `sp_act_in`. Otherwise the pointers pass through unexchanged.
- R9: `cycles` reports 16 for `op` 3/4/5, 12 for `op` 2, 6 for `op` 0 (read to register) and 8 for `op` 1 (read to memory).
- R10: For `op` 0 and `op` 1, `rd_data` equals the full status word, `sr` is unchanged, and `is_word` has no effect.
- R11: `op` 6 and `op` 7 complete with `sr` unchanged, no exception, pointers passed through and `cycles`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one operation when idle |
| op | input | 3 | 0 read-reg, 1 read-mem, 2 move, 3 OR, 4 AND, 5 XOR |
| is_word | input | 1 | 1 = full word, 0 = condition byte only |
| src | input | 16 | Source operand or immediate |
| sp_act_in | input | SP_W | Active stack pointer |
| sp_alt_in | input | SP_W | Alternate stack pointer |
| op_pc | input | PC_W | Address just past the opcode word |
| done | output | 1 | One-cycle completion pulse |
| sr | output | 16 | Status word |
| rd_data | output | 16 | Status value for read operations |
| sp_act_out | output | SP_W | Resulting active stack pointer |
| sp_alt_out | output | SP_W | Resulting alternate stack pointer |
| exc_req | output | 1 | Privilege exception request (with done) |
| exc_vec | output | 8 | Exception vector offset |
| exc_pc | output | PC_W | Return address of the faulting opcode |
| cycles | output | 6 | Cycle cost of the operation |

## Verification
The bench builds the unit with SP_W=24 and PC_W=20, so the pointer and address paths are narrower than the 32-bit defaults. That makes width-sensitive faults in the pointer exchange visible. It also lets a trap at `op_pc`=0 check the wrap of the rewound return address to 0xFFFFE. The sequence moves the unit from supervisor to user mode through an XOR that clears the supervisor flag, then checks traps, byte-form writes and reads in user mode, and resets again to reach the supervisor path a second time.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int SR_W      = 16;
    localparam int CYC_W     = 6;
    localparam int SUP_IDX   = 13;
    localparam logic [7:0]  CCR_KEEP  = 8'h1F;
    localparam logic [7:0]  SYS_KEEP  = 8'hA7;
    localparam logic [15:0] SR_RESET  = 16'h2700;
    localparam logic [7:0]  TRAP_VEC  = 8'h20;

    localparam logic [CYC_W-1:0] CYC_LOGIC = 6'd16;
    localparam logic [CYC_W-1:0] CYC_MOVE  = 6'd12;
    localparam logic [CYC_W-1:0] CYC_RDREG = 6'd6;
    localparam logic [CYC_W-1:0] CYC_RDMEM = 6'd8;
    localparam logic [CYC_W-1:0] CYC_TRAP  = 6'd34;

    typedef enum logic [2:0] {
        OP_RD_REG = 3'd0,
        OP_RD_MEM = 3'd1,
        OP_MOVE   = 3'd2,
        OP_OR     = 3'd3,
        OP_AND    = 3'd4,
        OP_XOR    = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } psw_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EVAL = 2'd1,
        S_RESP = 2'd2
    } psw_state_e;
endpackage

// File: rtl/psw_alu.sv
module psw_alu
    import psw_pkg::*;
(
    input  logic [2:0]       op,
    input  logic             is_word,
    input  logic [SR_W-1:0]  cur,
    input  logic [SR_W-1:0]  src,
    output logic [SR_W-1:0]  nxt,
    output logic             needs_priv,
    output logic [CYC_W-1:0] cost
);
    logic [SR_W-1:0] raw;
    logic            is_write;

    always_comb begin
        raw      = cur;
        is_write = 1'b0;
        cost     = '0;
        unique case (psw_op_e'(op))
            OP_RD_REG: cost = CYC_RDREG;
            OP_RD_MEM: cost = CYC_RDMEM;
            OP_MOVE: begin
                is_write = 1'b1;
                cost     = CYC_MOVE;
                raw      = is_word ? src : {cur[15:8], src[7:0]};
            end
            OP_OR, OP_AND, OP_XOR: begin
                is_write = 1'b1;
                cost     = CYC_LOGIC;
                if (psw_op_e'(op) == OP_OR)       raw = cur | src;
                else if (psw_op_e'(op) == OP_AND) raw = cur & src;
                else                              raw = cur ^ src;
                if (!is_word) raw = {cur[15:8], raw[7:0]};
            end
            default: cost = '0;
        endcase
    end

    assign nxt        = is_write ? {raw[15:8] & SYS_KEEP, raw[7:0] & CCR_KEEP} : cur;
    assign needs_priv = is_write & is_word;
endmodule

// File: rtl/psw_guard.sv
module psw_guard #(
    parameter int SP_W      = 32,
    parameter int PC_W      = 32,
    parameter int OPW_BYTES = 2
) (
    input  logic            cur_sup,
    input  logic            nxt_sup,
    input  logic            needs_priv,
    input  logic [SP_W-1:0] act_in,
    input  logic [SP_W-1:0] alt_in,
    input  logic [PC_W-1:0] pc_in,
    output logic            trap,
    output logic [SP_W-1:0] act_out,
    output logic [SP_W-1:0] alt_out,
    output logic [PC_W-1:0] trap_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(OPW_BYTES);
    logic swap;

    assign trap    = needs_priv & ~cur_sup;
    assign swap    = ~trap & (cur_sup ^ nxt_sup);
    assign act_out = swap ? alt_in : act_in;
    assign alt_out = swap ? act_in : alt_in;
    assign trap_pc = pc_in - STEP;
endmodule

// File: rtl/psw_update.sv
module psw_update
    import psw_pkg::*;
#(
    parameter int SP_W      = 32,
    parameter int PC_W      = 32,
    parameter int OPW_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic             is_word,
    input  logic [15:0]      src,
    input  logic [SP_W-1:0]  sp_act_in,
    input  logic [SP_W-1:0]  sp_alt_in,
    input  logic [PC_W-1:0]  op_pc,
    output logic             done,
    output logic [15:0]      sr,
    output logic [15:0]      rd_data,
    output logic [SP_W-1:0]  sp_act_out,
    output logic [SP_W-1:0]  sp_alt_out,
    output logic             exc_req,
    output logic [7:0]       exc_vec,
    output logic [PC_W-1:0]  exc_pc,
    output logic [5:0]       cycles
);
    psw_state_e st, st_nxt;

    logic [2:0]       l_op;
    logic             l_word;
    logic [SR_W-1:0]  l_src;
    logic [SP_W-1:0]  l_act, l_alt;
    logic [PC_W-1:0]  l_pc;

    logic [SR_W-1:0]  sr_q, rd_q;
    logic [SP_W-1:0]  act_q, alt_q;
    logic             exc_q;
    logic [PC_W-1:0]  epc_q;
    logic [CYC_W-1:0] cyc_q;

    logic [SR_W-1:0]  alu_nxt;
    logic             alu_priv;
    logic [CYC_W-1:0] alu_cost;
    logic             g_trap;
    logic [SP_W-1:0]  g_act, g_alt;
    logic [PC_W-1:0]  g_pc;

    psw_alu u_alu (
        .op         (l_op),
        .is_word    (l_word),
        .cur        (sr_q),
        .src        (l_src),
        .nxt        (alu_nxt),
        .needs_priv (alu_priv),
        .cost       (alu_cost)
    );

    psw_guard #(.SP_W(SP_W), .PC_W(PC_W), .OPW_BYTES(OPW_BYTES)) u_guard (
        .cur_sup    (sr_q[SUP_IDX]),
        .nxt_sup    (alu_nxt[SUP_IDX]),
        .needs_priv (alu_priv),
        .act_in     (l_act),
        .alt_in     (l_alt),
        .pc_in      (l_pc),
        .trap       (g_trap),
        .act_out    (g_act),
        .alt_out    (g_alt),
        .trap_pc    (g_pc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE: if (start) st_nxt = S_EVAL;
            S_EVAL: st_nxt = S_RESP;
            S_RESP: st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    // operand latch and commit datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            l_op   <= '0;
            l_word <= 1'b0;
            l_src  <= '0;
            l_act  <= '0;
            l_alt  <= '0;
            l_pc   <= '0;
            sr_q   <= SR_RESET;
            rd_q   <= '0;
            act_q  <= '0;
            alt_q  <= '0;
            exc_q  <= 1'b0;
            epc_q  <= '0;
            cyc_q  <= '0;
        end else begin
            if (st == S_IDLE && start) begin
                l_op   <= op;
                l_word <= is_word;
                l_src  <= src;
                l_act  <= sp_act_in;
                l_alt  <= sp_alt_in;
                l_pc   <= op_pc;
            end
            if (st == S_EVAL) begin
                rd_q  <= sr_q;
                act_q <= g_act;
                alt_q <= g_alt;
                exc_q <= g_trap;
                epc_q <= g_pc;
                if (g_trap) begin
                    cyc_q <= CYC_TRAP;
                end else begin
                    cyc_q <= alu_cost;
                    sr_q  <= alu_nxt;
                end
            end
        end
    end

    // outputs
    always_comb begin
        done       = (st == S_RESP);
        exc_req    = done & exc_q;
        exc_vec    = exc_req ? TRAP_VEC : 8'h00;
        exc_pc     = epc_q;
        sr         = sr_q;
        rd_data    = rd_q;
        sp_act_out = act_q;
        sp_alt_out = alt_q;
        cycles     = cyc_q;
    end
endmodule

module psw_update_chk #(
    parameter int SP_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            done,
    input logic [15:0]     sr,
    input logic            exc_req,
    input logic [7:0]      exc_vec,
    input logic [5:0]      cycles,
    input logic [SP_W-1:0] sp_act_in,
    input logic [SP_W-1:0] sp_alt_in,
    input logic [SP_W-1:0] sp_act_out,
    input logic [SP_W-1:0] sp_alt_out
);
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_sr_shape_r3: assert property (@(posedge clk) disable iff (rst)
        (sr[7:5] == 3'b000) && ((sr[15:8] & 8'h58) == 8'h00));

    p_trap_report_r6: assert property (@(posedge clk) disable iff (rst)
        (done && exc_req) |-> ($stable(sr) && !sr[13] && exc_vec == 8'h20 && cycles == 6'd34));

    p_swap_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !exc_req && (sr[13] != $past(sr[13])))
            |-> (sp_act_out == $past(sp_alt_in, 2) && sp_alt_out == $past(sp_act_in, 2)));

    p_noswap_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !exc_req && (sr[13] == $past(sr[13])))
            |-> (sp_act_out == $past(sp_act_in, 2) && sp_alt_out == $past(sp_alt_in, 2)));
endmodule

bind psw_update psw_update_chk #(.SP_W(SP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .sr         (sr),
    .exc_req    (exc_req),
    .exc_vec    (exc_vec),
    .cycles     (cycles),
    .sp_act_in  (sp_act_in),
    .sp_alt_in  (sp_alt_in),
    .sp_act_out (sp_act_out),
    .sp_alt_out (sp_alt_out)
);

// File: tb/psw_update_test.sv
module psw_update_test;
    localparam int SPW = 24;
    localparam int PCW = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [2:0]     op = 3'd0;
    logic           is_word = 1'b0;
    logic [15:0]    src = 16'h0;
    logic [SPW-1:0] act_i = '0, alt_i = '0;
    logic [PCW-1:0] pc_i = '0;

    logic           done, exc_req;
    logic [15:0]    sr, rd_data;
    logic [SPW-1:0] act_o, alt_o;
    logic [7:0]     exc_vec;
    logic [PCW-1:0] exc_pc;
    logic [5:0]     cycles;

    psw_update #(.SP_W(SPW), .PC_W(PCW), .OPW_BYTES(2)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .is_word(is_word), .src(src),
        .sp_act_in(act_i), .sp_alt_in(alt_i), .op_pc(pc_i),
        .done(done), .sr(sr), .rd_data(rd_data), .sp_act_out(act_o), .sp_alt_out(alt_o),
        .exc_req(exc_req), .exc_vec(exc_vec), .exc_pc(exc_pc), .cycles(cycles)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_sr = 16'h2700;
    logic        m_done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        chk(done === m_done, tag, "done", longint'(done), longint'(m_done));
        chk(sr === m_sr, tag, "sr", longint'(sr), longint'(m_sr));
    endtask

    task automatic run_op(input logic [2:0] o, input bit w, input logic [15:0] s,
                          input logic [SPW-1:0] a, input logic [SPW-1:0] b,
                          input logic [PCW-1:0] p, input bit busy, input string tag);
        logic [15:0] raw, nsr, old;
        logic [PCW-1:0] epc;
        bit wr, trap, swp;
        int cyc;
        old = m_sr;
        wr  = (o >= 3'd2) && (o <= 3'd5);
        case (o)
            3'd2:    raw = w ? s : {m_sr[15:8], s[7:0]};
            3'd3:    raw = m_sr | s;
            3'd4:    raw = m_sr & s;
            3'd5:    raw = m_sr ^ s;
            default: raw = m_sr;
        endcase
        if (o >= 3'd3 && o <= 3'd5 && !w) raw = {m_sr[15:8], raw[7:0]};
        nsr  = wr ? (raw & 16'hA71F) : m_sr;
        trap = wr && w && !m_sr[13];
        case (o)
            3'd0: cyc = 6;
            3'd1: cyc = 8;
            3'd2: cyc = 12;
            3'd3, 3'd4, 3'd5: cyc = 16;
            default: cyc = 0;
        endcase
        if (trap) cyc = 34;
        swp = !trap && (nsr[13] != m_sr[13]);
        epc = p - PCW'(2);

        op = o; is_word = w; src = s; act_i = a; alt_i = b; pc_i = p; start = 1'b1;
        tick(tag);
        if (busy) begin
            op = 3'd5; is_word = 1'b1; src = 16'hFFFF; start = 1'b1;
        end else begin
            start = 1'b0;
        end
        m_done = 1'b1;
        if (!trap) m_sr = nsr;
        tick(tag);
        chk(exc_req === trap, tag, "exc_req", longint'(exc_req), longint'(trap));
        if (trap) begin
            chk(exc_vec === 8'h20, tag, "exc_vec", longint'(exc_vec), 64'h20);
            chk(exc_pc === epc, tag, "exc_pc", longint'(exc_pc), longint'(epc));
        end else begin
            chk(act_o === (swp ? b : a), tag, "sp_act", longint'(act_o), longint'(swp ? b : a));
            chk(alt_o === (swp ? a : b), tag, "sp_alt", longint'(alt_o), longint'(swp ? a : b));
        end
        chk(cycles === 6'(cyc), tag, "cycles", longint'(cycles), longint'(cyc));
        if (o <= 3'd1)
            chk(rd_data === old, tag, "rd_data", longint'(rd_data), longint'(old));
        start = 1'b0;
        m_done = 1'b0;
        tick(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        m_sr = 16'h2700;
        m_done = 1'b0;
        tick("R1");
        chk(exc_req === 1'b0, "R1", "exc_req", longint'(exc_req), 0);
        chk(act_o === '0, "R1", "sp_act", longint'(act_o), 0);
        chk(alt_o === '0, "R1", "sp_alt", longint'(alt_o), 0);
        chk(cycles === 6'd0, "R1", "cycles", longint'(cycles), 0);
        chk(rd_data === 16'h0, "R1", "rd_data", longint'(rd_data), 0);
        rst = 1'b0;
        tick("R1");
    endtask

    initial begin
        do_reset();
        // reads in supervisor mode, is_word ignored (R10, R9)
        run_op(3'd0, 1'b1, 16'hFFFF, 24'h000100, 24'h000200, 20'h00100, 1'b0, "R10");
        run_op(3'd1, 1'b0, 16'h0000, 24'h000100, 24'h000200, 20'h00100, 1'b0, "R9");
        // byte move, flags layout (R4, R3)
        run_op(3'd2, 1'b0, 16'hFFFF, 24'h000100, 24'h000200, 20'h00100, 1'b0, "R4");
        // byte AND keeps high byte (R5)
        run_op(3'd4, 1'b0, 16'h0005, 24'h000100, 24'h000200, 20'h00100, 1'b0, "R5");
        // word OR, masked low byte (R5, R3)
        run_op(3'd3, 1'b1, 16'h00F0, 24'h000100, 24'h000200, 20'h00100, 1'b0, "R5");
        // XOR zero with start held during the operation (R2)
        run_op(3'd5, 1'b1, 16'h0000, 24'h000100, 24'h000200, 20'h00100, 1'b1, "R2");
        // word move all ones, upper mask 0xA7 (R4, R3)
        run_op(3'd2, 1'b1, 16'hFFFF, 24'h000100, 24'h000200, 20'h00100, 1'b0, "R3");
        // XOR clears supervisor bit, pointers exchange (R8)
        run_op(3'd5, 1'b1, 16'h2000, 24'h001000, 24'h002000, 20'h00100, 1'b0, "R8");
        // user mode word writes trap (R6)
        run_op(3'd2, 1'b1, 16'h2700, 24'h001000, 24'h002000, 20'h00400, 1'b0, "R6");
        run_op(3'd3, 1'b1, 16'h2000, 24'h001000, 24'h002000, 20'h00000, 1'b0, "R6");
        // user mode byte forms and reads proceed (R7)
        run_op(3'd4, 1'b0, 16'h0003, 24'h001000, 24'h002000, 20'h00100, 1'b0, "R7");
        run_op(3'd0, 1'b0, 16'h0000, 24'h001000, 24'h002000, 20'h00100, 1'b0, "R7");
        run_op(3'd2, 1'b0, 16'h00EA, 24'h001000, 24'h002000, 20'h00100, 1'b0, "R7");
        // reserved codes (R11)
        run_op(3'd6, 1'b1, 16'hFFFF, 24'h003000, 24'h004000, 20'h00100, 1'b0, "R11");
        run_op(3'd7, 1'b0, 16'h0000, 24'h003000, 24'h004000, 20'h00100, 1'b0, "R11");
        // back to supervisor by reset, byte XOR then supervisor drop by move (R1, R5, R8)
        do_reset();
        run_op(3'd5, 1'b0, 16'h00FF, 24'h00ABCD, 24'h00DCBA, 20'h00100, 1'b0, "R5");
        run_op(3'd2, 1'b1, 16'h0004, 24'h00ABCD, 24'h00DCBA, 20'h00100, 1'b0, "R8");
        run_op(3'd1, 1'b1, 16'h0000, 24'h00ABCD, 24'h00DCBA, 20'h00100, 1'b0, "R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule